// File: doc/BRIEF.md
# Cascaded Pattern Trigger for a Logic Sampler

This block watches a parallel sample stream and raises a one-cycle trigger pulse when a programmed sequence of channel conditions has been seen. It holds four trigger stages. Each stage carries a channel mask, a compare value, an edge-select word and a configuration word. Per masked channel, the stage tests for a low or high level, or for a rising or falling transition against the previous valid sample. A stage is only eligible while the shared progress counter equals the level number in its configuration word, so stages fire in sequence. A match on an eligible stage either advances the counter or, if the stage carries the start flag, ends the search with a trigger pulse.

Configuration arrives as byte writes. Four writes to one register address build a 32-bit word, least significant byte first. The register address is a base code plus four times the stage index plus a register-kind offset. An arm pulse restarts the search from level 0. A stage with an all-zero mask and value at the top level counts as switched off. The usual "trigger now" setup is a zero-mask stage at level 0 with the start flag, which fires on the first valid sample after arming.

Top module: `multi_stage_trigger`

## Requirements
- R1: Each byte write advances a 2-bit phase. The address is taken from the first byte of a group, and bytes fill the word from bit 0 upward. A register changes only when the fourth byte arrives. Address = 0xC0 + 4*stage + kind, where kind 0 is mask, 1 is value, 2 is configuration and 3 is edge-select.
- R2: In a channel whose edge-select bit is 0, a set mask bit requires the sample bit to equal the value bit. A stage matches when every masked channel meets its condition, so a zero mask matches every valid sample.
- R3: In a channel whose edge-select bit is 1, value bit 1 requires a 0-to-1 change and value bit 0 requires a 1-to-0 change, both measured against the previous valid sample. No edge can match before the first valid sample since reset.
- R4: A stage is eligible only while its level field (configuration bits 17:16) equals the progress counter. A match on an eligible stage without the start flag raises the counter by one. The counter saturates at the top level.
- R5: A match on an eligible stage whose start flag (configuration bit 27) is set drives trig_o high for exactly the one cycle after that sample. No further pulse occurs until the next arm.
- R6: A stage whose mask and value are both zero and whose level is 3 never matches, even while eligible.
- R7: arm_i sets the progress counter to 0 and starts the search. A sample presented in the arm cycle is not matched. Before the first arm nothing fires.
- R8: A cycle without sample_valid_i neither matches nor updates the previous-sample register.
- R9: Reset clears all stage registers to zero, idles the search and holds trig_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_addr_i | input | ADDR_W | Register address of the byte |
| wr_byte_i | input | 8 | Write data byte |
| arm_i | input | 1 | Restart the trigger search at level 0 |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | NUM_CH | Channel sample word |
| trig_o | output | 1 | One-cycle capture-start pulse |

## Verification
The bench builds the block with its defaults: 32 channels, four stages and an 8-bit address with base 0xC0. This puts the disabled top level 3 and full 32-bit words in reach. With four stages, a three-step chain followed by a switched-off final stage can run to saturation within a few cycles. The wide words let the byte-order check tell a low-byte pattern apart from its mirror in the high byte.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int REG_W         = 32;
  localparam int CFG_LVL_LSB   = 16;
  localparam int CFG_START_BIT = 27;

  typedef enum logic [1:0] {
    KIND_MASK  = 2'd0,
    KIND_VALUE = 2'd1,
    KIND_CFG   = 2'd2,
    KIND_EDGE  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] value;
    logic [REG_W-1:0] cfg;
    logic [REG_W-1:0] edge_sel;
  } stage_cfg_t;
endpackage

// File: rtl/trig_loader.sv
module trig_loader
  import trig_pkg::*;
#(
  parameter int                NUM_STAGES = 4,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_BASE  = 8'hC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_byte_i,
  output stage_cfg_t        cfg_o [NUM_STAGES],
  output logic [1:0]        phase_o
);
  localparam int SPAN = NUM_STAGES * 4;

  logic [1:0]        phase_q;
  logic [23:0]       shadow_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] tgt_addr, off;
  logic              commit, in_range;
  logic [REG_W-1:0]  word;
  reg_kind_e         kind;

  // address of a group is the one seen with its first byte
  assign tgt_addr = (phase_q == 2'd0) ? wr_addr_i : addr_q;
  assign off      = tgt_addr - ADDR_BASE;
  assign in_range = (tgt_addr >= ADDR_BASE) && (off < ADDR_W'(SPAN));
  assign commit   = wr_en_i && (phase_q == 2'd3) && in_range;
  assign word     = {wr_byte_i, shadow_q};
  assign kind     = reg_kind_e'(off[1:0]);
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      shadow_q <= '0;
      addr_q   <= '0;
    end else if (wr_en_i) begin
      phase_q  <= phase_q + 2'd1;
      shadow_q <= {wr_byte_i, shadow_q[23:8]};
      if (phase_q == 2'd0) addr_q <= wr_addr_i;
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic hit_s;
    assign hit_s = commit && (off[ADDR_W-1:2] == (ADDR_W-2)'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[s] <= '0;
      end else if (hit_s) begin
        unique case (kind)
          KIND_MASK:  cfg_o[s].mask     <= word;
          KIND_VALUE: cfg_o[s].value    <= word;
          KIND_CFG:   cfg_o[s].cfg      <= word;
          KIND_EDGE:  cfg_o[s].edge_sel <= word;
        endcase
      end
    end
  end
endmodule

// File: rtl/trig_stage.sv
module trig_stage
  import trig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int LVL_W  = 2
) (
  input  stage_cfg_t        cfg_i,
  input  logic [NUM_CH-1:0] cur_i,
  input  logic [NUM_CH-1:0] prev_i,
  input  logic              have_prev_i,
  output logic              hit_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              start_o
);
  logic [NUM_CH-1:0] val, msk, esel, lvl_ok, rise, fall, edg_ok, cond;
  logic              off_stage;

  assign val  = cfg_i.value[NUM_CH-1:0];
  assign msk  = cfg_i.mask[NUM_CH-1:0];
  assign esel = cfg_i.edge_sel[NUM_CH-1:0];

  assign level_o = cfg_i.cfg[CFG_LVL_LSB +: LVL_W];
  assign start_o = cfg_i.cfg[CFG_START_BIT];

  assign lvl_ok = ~(cur_i ^ val);
  assign rise   = ~prev_i & cur_i;
  assign fall   = prev_i & ~cur_i;
  assign edg_ok = ((val & rise) | (~val & fall)) & {NUM_CH{have_prev_i}};
  assign cond   = (esel & edg_ok) | (~esel & lvl_ok);

  // all-zero compare words at the top level mark an unused stage
  assign off_stage = (cfg_i.mask == '0) && (cfg_i.value == '0) && (&level_o);
  assign hit_o     = (&(~msk | cond)) && !off_stage;
endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int NUM_STAGES = 4,
  parameter int LVL_W      = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             arm_i,
  input  logic                             valid_i,
  input  logic [NUM_STAGES-1:0]            hit_i,
  input  logic [NUM_STAGES-1:0]            start_i,
  input  logic [NUM_STAGES-1:0][LVL_W-1:0] level_i,
  output logic [LVL_W-1:0]                 lvl_o,
  output logic                             trig_o
);
  logic                  run_q, trig_q;
  logic [LVL_W-1:0]      lvl_q;
  logic [NUM_STAGES-1:0] elig;
  logic                  fire, adv;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_elig
    assign elig[s] = run_q && valid_i && !arm_i && hit_i[s] && (level_i[s] == lvl_q);
  end

  assign fire = |(elig & start_i);
  assign adv  = |(elig & ~start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      lvl_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= fire;
      if (arm_i) begin
        run_q <= 1'b1;
        lvl_q <= '0;
      end else if (fire) begin
        run_q <= 1'b0;
      end else if (adv && !(&lvl_q)) begin
        lvl_q <= lvl_q + 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/multi_stage_trigger.sv
module multi_stage_trigger
  import trig_pkg::*;
#(
  parameter int                NUM_CH     = 32,
  parameter int                NUM_STAGES = 4,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_BASE  = 8'hC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              arm_i,
  input  logic              sample_valid_i,
  input  logic [NUM_CH-1:0] sample_i,
  output logic              trig_o
);
  localparam int LVL_W = $clog2(NUM_STAGES);

  stage_cfg_t                      cfg [NUM_STAGES];
  logic [1:0]                      wr_phase;
  logic [NUM_CH-1:0]               prev_q;
  logic                            have_prev_q;
  logic [NUM_STAGES-1:0]           hit, start;
  logic [NUM_STAGES-1:0][LVL_W-1:0] level;
  logic [LVL_W-1:0]                progress;

  trig_loader #(
    .NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE)
  ) u_loader (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_byte_i,
    .cfg_o(cfg), .phase_o(wr_phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (sample_valid_i) begin
      prev_q      <= sample_i;
      have_prev_q <= 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    trig_stage #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_stage (
      .cfg_i(cfg[s]), .cur_i(sample_i), .prev_i(prev_q),
      .have_prev_i(have_prev_q),
      .hit_o(hit[s]), .level_o(level[s]), .start_o(start[s])
    );
  end

  trig_seq #(.NUM_STAGES(NUM_STAGES), .LVL_W(LVL_W)) u_seq (
    .clk_i, .rst_ni, .arm_i, .valid_i(sample_valid_i),
    .hit_i(hit), .start_i(start), .level_i(level),
    .lvl_o(progress), .trig_o
  );
endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int LVL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             sample_valid_i,
  input logic             wr_en_i,
  input logic             trig_o,
  input logic [LVL_W-1:0] progress,
  input logic [1:0]       wr_phase
);
  p_trig_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_arm_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !trig_o);

  p_arm_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (progress == '0));

  p_invalid_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !trig_o);

  p_progress_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> ((progress == $past(progress)) ||
                (progress == LVL_W'($past(progress) + 1'b1))));

  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (wr_phase == 2'($past(wr_phase) + 2'd1)));

  p_phase_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_phase));
endmodule

bind multi_stage_trigger trig_checker #(.LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i),
  .sample_valid_i(sample_valid_i), .wr_en_i(wr_en_i), .trig_o(trig_o),
  .progress(progress), .wr_phase(wr_phase)
);

// File: tb/tb_multi_stage_trigger.sv
module tb_multi_stage_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_byte = '0;
  logic        arm = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] smp_d = '0;
  logic        trig;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb [$];

  always #2 clk = ~clk;

  multi_stage_trigger dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_byte_i(wr_byte), .arm_i(arm), .sample_valid_i(vld),
    .sample_i(smp_d), .trig_o(trig)
  );

  // monitor: compares trig_o just after each edge against the queue
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (trig !== it.exp) begin
        bad++;
        $display("FAIL %s: trig_o=%0b expected=%0b", it.tag, trig, it.exp);
      end
    end
  end

  task automatic cyc(input bit a, input bit v, input logic [31:0] d,
                     input bit we, input logic [7:0] ad, input logic [7:0] b,
                     input bit e, input string tag);
    exp_t it;
    @(negedge clk);
    arm = a; vld = v; smp_d = d; wr_en = we; wr_addr = ad; wr_byte = b;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic smp(input logic [31:0] d, input bit e, input string tag);
    cyc(1'b0, 1'b1, d, 1'b0, 8'h00, 8'h00, e, tag);
  endtask

  task automatic do_arm();
    cyc(1'b1, 1'b0, 32'h0, 1'b0, 8'h00, 8'h00, 1'b0, "R7");
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h00, 1'b0, tag);
  endtask

  task automatic wbyte(input int s, input int k, input logic [7:0] b);
    cyc(1'b0, 1'b0, 32'h0, 1'b1, 8'(8'hC0 + s * 4 + k), b, 1'b0, "R1");
  endtask

  task automatic wr_reg(input int s, input int k, input logic [31:0] w);
    for (int i = 0; i < 4; i++) wbyte(s, k, w[8*i +: 8]);
  endtask

  function automatic logic [31:0] cfgw(input int lvl, input bit st);
    return (32'(st) << 27) | (32'(lvl) << 16);
  endfunction

  task automatic set_stage(input int s, input logic [31:0] m, input logic [31:0] v,
                           input logic [31:0] ed, input logic [31:0] c);
    wr_reg(s, 0, m); wr_reg(s, 1, v); wr_reg(s, 2, c); wr_reg(s, 3, ed);
  endtask

  task automatic switch_off_upper();
    for (int s = 1; s < 4; s++) set_stage(s, 32'h0, 32'h0, 32'h0, cfgw(3, 1'b0));
  endtask

  task automatic do_reset();
    idle("R9"); idle("R9");
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    checks++; bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (trig !== 1'b0) begin
      bad++;
      $display("FAIL R9: trig_o=%0b expected=0 in reset", trig);
    end
    rst_n = 1'b1;

    // R9: cleared registers never carry a start flag
    do_arm();
    smp(32'h0000_0001, 1'b0, "R9");
    smp(32'hFFFF_FFFF, 1'b0, "R9");
    smp(32'h1234_5678, 1'b0, "R9");

    // R2/R5: zero-mask start stage fires at once after arm
    switch_off_upper();
    set_stage(0, 32'h0, 32'h0, 32'h0, cfgw(0, 1'b1));
    smp(32'h1234, 1'b0, "R7");
    do_arm();
    idle("R8");
    smp(32'h1234, 1'b1, "R5");
    smp(32'h1234, 1'b0, "R5");
    smp(32'h4321, 1'b0, "R5");
    do_arm();
    smp(32'hDEAD_BEEF, 1'b1, "R2");

    // R1/R2: byte order and commit on the fourth byte
    wr_reg(0, 0, 32'h0000_00FF);
    wr_reg(0, 1, 32'h0000_00A5);
    do_arm();
    smp(32'hFFFF_FF5A, 1'b0, "R2");
    smp(32'h1234_56A5, 1'b1, "R1");
    do_arm();
    wbyte(0, 0, 8'h00); wbyte(0, 0, 8'h00); wbyte(0, 0, 8'h00);
    smp(32'hFFFF_FF5A, 1'b0, "R1");
    wbyte(0, 0, 8'h00);
    smp(32'hFFFF_FF5A, 1'b1, "R1");

    // R3/R8: ch0 rising, ch1 falling; invalid cycle leaves prev alone
    set_stage(0, 32'h3, 32'h1, 32'h3, cfgw(0, 1'b1));
    do_arm();
    smp(32'h2, 1'b0, "R3");
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h00, 1'b0, "R8");
    smp(32'h1, 1'b1, "R3");

    // R4: three-step chain
    set_stage(0, 32'hFF, 32'h11, 32'h0, cfgw(0, 1'b0));
    set_stage(1, 32'hFF, 32'h22, 32'h0, cfgw(1, 1'b0));
    set_stage(2, 32'hFF, 32'h33, 32'h0, cfgw(2, 1'b1));
    do_arm();
    smp(32'h22, 1'b0, "R4");
    smp(32'h11, 1'b0, "R4");
    smp(32'h33, 1'b0, "R4");
    smp(32'h22, 1'b0, "R4");
    smp(32'h33, 1'b1, "R4");
    // R7: re-arm clears progress
    do_arm();
    smp(32'h33, 1'b0, "R7");
    smp(32'h11, 1'b0, "R7");
    smp(32'h22, 1'b0, "R7");
    smp(32'h33, 1'b1, "R7");
    // R7: sample in the arm cycle is not matched
    cyc(1'b1, 1'b1, 32'h11, 1'b0, 8'h00, 8'h00, 1'b0, "R7");
    smp(32'h22, 1'b0, "R7");
    smp(32'h33, 1'b0, "R7");
    smp(32'h11, 1'b0, "R7");
    smp(32'h22, 1'b0, "R7");
    smp(32'h33, 1'b1, "R7");

    // R6: switched-off top stage never fires, even with the start flag
    set_stage(0, 32'h0, 32'h0, 32'h0, cfgw(0, 1'b0));
    set_stage(1, 32'h0, 32'h0, 32'h0, cfgw(1, 1'b0));
    set_stage(2, 32'h0, 32'h0, 32'h0, cfgw(2, 1'b0));
    set_stage(3, 32'h0, 32'h0, 32'h0, cfgw(3, 1'b1));
    do_arm();
    for (int i = 0; i < 5; i++) smp(32'h0, 1'b0, "R6");
    wr_reg(3, 0, 32'h1);
    do_arm();
    smp(32'h0, 1'b0, "R6");
    smp(32'h0, 1'b0, "R6");
    smp(32'h0, 1'b0, "R6");
    smp(32'h0, 1'b1, "R6");

    // R9: reset wipes a ready-to-fire setup
    switch_off_upper();
    set_stage(0, 32'h0, 32'h0, 32'h0, cfgw(0, 1'b1));
    do_reset();
    smp(32'h0, 1'b0, "R7");
    do_arm();
    smp(32'h0, 1'b0, "R9");
    smp(32'h5, 1'b0, "R9");

    // R3: no edge before the first valid sample since reset
    do_reset();
    switch_off_upper();
    set_stage(0, 32'h1, 32'h1, 32'h1, cfgw(0, 1'b1));
    do_arm();
    smp(32'h1, 1'b0, "R3");
    smp(32'h0, 1'b0, "R3");
    smp(32'h1, 1'b1, "R3");

    idle("R5");
    idle("R5");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule